// File: doc/BRIEF.md
# Rotating Tiled Framebuffer Address Generator

This block produces one byte address per output pixel for a scaler that emits its pixels in raster order: left to right within a row, then row by row. A start pulse loads the output size, the pixel format, the rotation code and the tiling enable. From then on, every accepted pixel moves the walk one step. Each raster position is mapped through a clockwise rotation of 0, 90, 180 or 270 degrees into the stored image. It is then optionally regrouped into 8x8 tiles for a graphics engine, and finally scaled by the bytes per pixel of the chosen format.

When a quarter turn is selected, the stored image is as wide as the raster is tall. The address of the pixel being offered is always present on `addr_o` while `busy_o` is high. After the last pixel is accepted, the block pulses `done_o` and raises a level interrupt request. That request stays high until the next accepted start. A start with tiling on and a size that is not a multiple of 8 is refused and flagged.

Top module: `rot_fb_addr_gen`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `irq_o` and `cfg_err_o` are all 0.
- R2: A start while idle with a legal configuration sets `busy_o` on the next cycle, and `addr_o` then holds the address of raster pixel (0,0).
- R3: The walk advances only on a clock edge where `pix_accept_i` and `busy_o` are both high. Otherwise `addr_o` holds its value.
- R4: With rotation code 0 and tiling off, raster pixel (x,y) is stored at index y*W+x. While `busy_o` is high, the address is below W*H*bytes per pixel.
- R5: Rotation code 1 (90 degrees clockwise) places raster pixel (x,y) at stored column H-1-y and stored row x. The stored width is H.
- R6: Rotation code 2 (180 degrees, not mirrored) places raster pixel (x,y) at stored column W-1-x and stored row H-1-y. The stored width is W.
- R7: Rotation code 3 (270 degrees clockwise) places raster pixel (x,y) at stored column y and stored row W-1-x. The stored width is H.
- R8: The byte address equals the stored index times the bytes per pixel. The format code sets the bytes per pixel: 0 gives 4, 1 gives 3, and 2 or 3 give 2.
- R9: With tiling on, and stored width SW, stored column u and stored row v, the index is (v/8)*SW*8 + (u/8)*64 + (v%8)*8 + (u%8). Tiles are therefore row-major, and pixels inside each tile are row-major.
- R10: The edge that accepts the last of the W*H pixels clears `busy_o` and raises `done_o` for exactly one cycle.
- R11: `irq_o` rises together with `done_o` and stays high until the next accepted start clears it.
- R12: A start with tiling on, where W or H is not a multiple of 8, leaves `busy_o` low and sets `cfg_err_o`. The next accepted start clears `cfg_err_o`.
- R13: A start while `busy_o` is high is ignored. The walk continues with the configuration it started with.
- R14: W-1 is read from `dims_i` bits 8:0 and H-1 from bits 24:16, each giving a legal range of 1 to 512. All other bits of `dims_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; loads the configuration when idle |
| pix_accept_i | input | 1 | The pixel at `addr_o` has been taken |
| dims_i | input | 32 | W-1 in bits 8:0, H-1 in bits 24:16 |
| pix_fmt_i | input | 2 | Format code: 0 = 4, 1 = 3, 2/3 = 2 bytes per pixel |
| rot_i | input | 2 | Rotation code: 0, 90, 180, 270 degrees clockwise |
| tile_en_i | input | 1 | Store the image as 8x8 tiles |
| addr_o | output | 20 | Byte address of the current pixel |
| busy_o | output | 1 | A walk is in progress; `addr_o` is valid |
| done_o | output | 1 | One-cycle pulse after the last pixel |
| irq_o | output | 1 | Completion interrupt request, held until the next start |
| cfg_err_o | output | 1 | The last start was refused for a bad tiled size |

## Verification
The in-line properties check several rules on every cycle: the coordinates hold while no pixel is accepted, and the address stays inside the stored image. They also check that `done_o` is a single pulse that never coincides with `busy_o`, and that the interrupt level persists. A refused start keeps the block idle, and a start during a walk does not end it early. The exact address of each pixel depends on the rotation, the tiling and the format. Only the bench's scenarios can show those values, by comparing each one against an independent model. The same holds for the ignored bits of `dims_i` and for the configuration surviving a start issued mid-walk.

// File: rtl/fbag_pkg.sv
package fbag_pkg;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  // format code to bytes per pixel (R8)
  function automatic logic [2:0] bytes_per_pix(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return 3'd4;
      2'd1:    return 3'd3;
      default: return 3'd2;
    endcase
  endfunction

endpackage

// File: rtl/fbag_walker.sv
module fbag_walker #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          step_i,
  input  logic [CW-1:0] wm1_i,
  input  logic [CW-1:0] hm1_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o,
  output logic          busy_o,
  output logic          last_o
);

  logic [CW-1:0] x_q, x_d, y_q, y_d;
  logic          busy_q, busy_d;

  assign last_o = (x_q == wm1_i) && (y_q == hm1_i);

  always_comb begin
    x_d    = x_q;
    y_d    = y_q;
    busy_d = busy_q;
    if (load_i) begin
      x_d    = '0;
      y_d    = '0;
      busy_d = 1'b1;
    end else if (step_i) begin
      if (x_q == wm1_i) begin
        x_d = '0;
        if (y_q == hm1_i) begin
          y_d    = '0;
          busy_d = 1'b0;
        end else begin
          y_d = y_q + 1'b1;
        end
      end else begin
        x_d = x_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q    <= '0;
      y_q    <= '0;
      busy_q <= 1'b0;
    end else if (load_i || step_i) begin
      x_q    <= x_d;
      y_q    <= y_d;
      busy_q <= busy_d;
    end
  end

  assign x_o    = x_q;
  assign y_o    = y_q;
  assign busy_o = busy_q;

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !step_i && !load_i) |=> ($stable(x_q) && $stable(y_q)));

  p_xy_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (x_q <= wm1_i && y_q <= hm1_i));

endmodule

// File: rtl/fbag_map.sv
module fbag_map
  import fbag_pkg::*;
#(
  parameter int CW = 9,
  parameter int AW = 2*CW+2
) (
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] wm1_i,
  input  logic [CW-1:0] hm1_i,
  input  logic [1:0]    rot_i,
  input  logic          tile_i,
  input  logic [1:0]    fmt_i,
  output logic [AW-1:0] addr_o
);

  logic [CW-1:0] u, v;
  logic [CW:0]   sw;
  logic [AW-1:0] lin_idx, tile_idx, idx;

  // rotate raster coordinates into stored column u, row v (R5..R7)
  always_comb begin
    case (rot_e'(rot_i))
      ROT_0:   begin u = x_i;         v = y_i;         end
      ROT_90:  begin u = hm1_i - y_i; v = x_i;         end
      ROT_180: begin u = wm1_i - x_i; v = hm1_i - y_i; end
      default: begin u = y_i;         v = wm1_i - x_i; end
    endcase
    sw = rot_i[0] ? ({1'b0, hm1_i} + (CW+1)'(1)) : ({1'b0, wm1_i} + (CW+1)'(1));
  end

  // a tile row spans 8 stored rows; inside a tile the offset is {v%8,u%8}
  always_comb begin
    lin_idx  = AW'(v) * AW'(sw) + AW'(u);
    tile_idx = ((AW'(v >> 3) * AW'(sw)) << 3) + (AW'(u >> 3) << 6)
             + AW'({v[2:0], u[2:0]});
    idx      = tile_i ? tile_idx : lin_idx;
    addr_o   = idx * AW'(bytes_per_pix(fmt_i));
  end

endmodule

// File: rtl/rot_fb_addr_gen.sv
module rot_fb_addr_gen
  import fbag_pkg::*;
#(
  parameter  int CW = 9,
  localparam int AW = 2*CW+2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          pix_accept_i,
  input  logic [31:0]   dims_i,
  input  logic [1:0]    pix_fmt_i,
  input  logic [1:0]    rot_i,
  input  logic          tile_en_i,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic          cfg_err_o
);

  localparam int HLSB = 16;

  logic [CW-1:0] wm1_in, hm1_in;
  logic [CW-1:0] wm1_q, hm1_q;
  logic [1:0]    rot_q, fmt_q;
  logic          tile_q;
  logic          done_q, done_d, irq_q, irq_d, err_q, err_d;
  logic          busy, last, cfg_ok, idle_start, go, step;
  logic [CW-1:0] x, y;
  logic          unused_dims;

  // R14: field positions
  assign wm1_in      = dims_i[CW-1:0];
  assign hm1_in      = dims_i[HLSB +: CW];
  assign unused_dims = ^{dims_i[31:HLSB+CW], dims_i[HLSB-1:CW]};

  always_comb begin
    cfg_ok     = !tile_en_i || ((&wm1_in[2:0]) && (&hm1_in[2:0]));
    idle_start = start_i && !busy;
    go         = idle_start && cfg_ok;
    step       = busy && pix_accept_i;
    done_d     = step && last;
    irq_d      = go ? 1'b0 : (done_d ? 1'b1 : irq_q);
    err_d      = go ? 1'b0 : ((idle_start && !cfg_ok) ? 1'b1 : err_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wm1_q  <= '0;
      hm1_q  <= '0;
      rot_q  <= '0;
      fmt_q  <= '0;
      tile_q <= 1'b0;
    end else if (go) begin
      wm1_q  <= wm1_in;
      hm1_q  <= hm1_in;
      rot_q  <= rot_i;
      fmt_q  <= pix_fmt_i;
      tile_q <= tile_en_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= done_d;
      irq_q  <= irq_d;
      err_q  <= err_d;
    end
  end

  fbag_walker #(.CW(CW)) u_walk (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (go),
    .step_i (step),
    .wm1_i  (wm1_q),
    .hm1_i  (hm1_q),
    .x_o    (x),
    .y_o    (y),
    .busy_o (busy),
    .last_o (last)
  );

  fbag_map #(.CW(CW), .AW(AW)) u_map (
    .x_i    (x),
    .y_i    (y),
    .wm1_i  (wm1_q),
    .hm1_i  (hm1_q),
    .rot_i  (rot_q),
    .tile_i (tile_q),
    .fmt_i  (fmt_q),
    .addr_o (addr_o)
  );

  assign busy_o    = busy;
  assign done_o    = done_q;
  assign irq_o     = irq_q;
  assign cfg_err_o = err_q;

  // bound on the stored image size, used only by the range check
  logic [AW:0] img_bytes;
  assign img_bytes = (AW+1)'(wm1_q + 1'b1) * (AW+1)'(hm1_q + 1'b1)
                   * (AW+1)'(bytes_per_pix(fmt_q));

  p_addr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((AW+1)'(addr_o) < img_bytes));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);

  p_irq_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !start_i) |=> irq_q);

  p_bad_cfg_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy && !cfg_ok) |=> (!busy && err_q));

  p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i && !(pix_accept_i && last)) |=> busy);

endmodule

// File: tb/sim_rot_fb_addr_gen.sv
module sim_rot_fb_addr_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        pix_accept_i = 1'b0;
  logic [31:0] dims_i = '0;
  logic [1:0]  pix_fmt_i = '0;
  logic [1:0]  rot_i = '0;
  logic        tile_en_i = 1'b0;
  logic [19:0] addr_o;
  logic        busy_o, done_o, irq_o, cfg_err_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5ns clk = ~clk;

  rot_fb_addr_gen u0 (.*);

  // {tile, rot, fmt, W-1, H-1}
  localparam int NV = 10;
  localparam logic [22:0] VEC [NV] = '{
    {1'b0, 2'd0, 2'd0, 9'd2,   9'd1},
    {1'b0, 2'd1, 2'd1, 9'd2,   9'd1},
    {1'b0, 2'd2, 2'd2, 9'd3,   9'd2},
    {1'b0, 2'd3, 2'd3, 9'd1,   9'd2},
    {1'b1, 2'd0, 2'd0, 9'd15,  9'd7},
    {1'b1, 2'd1, 2'd2, 9'd7,   9'd15},
    {1'b1, 2'd2, 2'd1, 9'd7,   9'd7},
    {1'b1, 2'd3, 2'd0, 9'd15,  9'd7},
    {1'b0, 2'd1, 2'd0, 9'd511, 9'd0},
    {1'b0, 2'd0, 2'd1, 9'd0,   9'd511}
  };

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model(int x, int y, int w, int h, int rot, int tile, int fmt);
    int u, v, sw, idx, bpp;
    case (rot)
      0: begin u = x;         v = y;         end
      1: begin u = h - 1 - y; v = x;         end
      2: begin u = w - 1 - x; v = h - 1 - y; end
      default: begin u = y;   v = w - 1 - x; end
    endcase
    sw = (rot % 2 == 1) ? h : w;
    if (tile != 0) idx = (v / 8) * sw * 8 + (u / 8) * 64 + (v % 8) * 8 + (u % 8);
    else           idx = v * sw + u;
    bpp = (fmt == 0) ? 4 : ((fmt == 1) ? 3 : 2);
    return idx * bpp;
  endfunction

  // R14: junk placed in every bit outside the two size fields
  function automatic logic [31:0] pack_dims(int w, int h);
    return {6'b101101, 1'b0, 9'(h - 1), 7'b1010101, 9'(w - 1)};
  endfunction

  task automatic do_start(int w, int h, int rot, int tile, int fmt);
    @(negedge clk);
    dims_i = pack_dims(w, h); rot_i = 2'(rot); tile_en_i = tile[0]; pix_fmt_i = 2'(fmt);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic accept_one();
    pix_accept_i = 1'b1;
    @(negedge clk);
    pix_accept_i = 1'b0;
  endtask

  initial begin
    #2ms;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0);
    chk("R1 irq", irq_o, 0);   chk("R1 err", cfg_err_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      int t, r, f, w, h;
      string tag;
      t = VEC[i][22]; r = VEC[i][21:20]; f = VEC[i][19:18];
      w = VEC[i][17:9] + 1; h = VEC[i][8:0] + 1;
      tag = (t != 0) ? "R9" : (r == 0 ? "R4" : r == 1 ? "R5" : r == 2 ? "R6" : "R7");
      tag = {tag, "/R8/R14"};
      do_start(w, h, r, t, f);
      chk("R2 busy after start", busy_o, 1);
      if (i == 0) chk("R11 irq cleared by start", irq_o, 0);
      for (int y = 0; y < h; y++) begin
        for (int x = 0; x < w; x++) begin
          chk(tag, addr_o, model(x, y, w, h, r, t, f));
          if (x == 1 && y == 0) begin
            repeat (2) begin
              @(negedge clk);
              chk("R3 hold without accept", addr_o, model(x, y, w, h, r, t, f));
            end
          end
          accept_one();
        end
      end
      chk("R10 done pulse", done_o, 1);
      chk("R10 busy cleared", busy_o, 0);
      chk("R11 irq raised", irq_o, 1);
      @(negedge clk);
      chk("R10 done one cycle", done_o, 0);
      repeat (3) @(negedge clk);
      chk("R11 irq held", irq_o, 1);
    end

    // R13: start during a walk is ignored
    do_start(4, 3, 0, 0, 0);
    accept_one(); accept_one();
    @(negedge clk);
    dims_i = pack_dims(8, 8); rot_i = 2'd2; pix_fmt_i = 2'd1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R13 still busy", busy_o, 1);
    for (int k = 2; k < 12; k++) begin
      chk("R13 original config kept", addr_o, model(k % 4, k / 4, 4, 3, 0, 0, 0));
      accept_one();
    end
    chk("R13 done after original count", done_o, 1);

    // R12: tiled start with width not a multiple of 8
    do_start(12, 8, 0, 1, 0);
    chk("R12 refused", busy_o, 0);
    chk("R12 error flag", cfg_err_o, 1);
    do_start(8, 12, 1, 1, 0);
    chk("R12 refused height", busy_o, 0);
    do_start(2, 2, 0, 0, 2);
    chk("R12 error cleared", cfg_err_o, 0);
    chk("R12 good start runs", busy_o, 1);
    chk("R8 fmt2 pixel0", addr_o, 0);
    accept_one();
    chk("R8 fmt2 pixel1", addr_o, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule